// File: doc/BRIEF.md
# Floating-point pairwise minimum unit

This unit takes one packed source word that holds two floating-point elements and returns the smaller of the two as a scalar result. A two-bit format code sets the element width to 16, 32 or 64 bits. The first element sits in the low half of the packed slice and the second element in the high half. Source bits above the selected slice are ignored. The result is zero-extended to 64 bits.

Two mode inputs control the special cases. With the alternate mode off, a negative zero orders below a positive zero. A NaN operand then produces either a quieted copy of a propagated NaN or, in default-NaN mode, the canonical NaN of the format. With the alternate mode on, a pair of zeros or any NaN operand returns the second element bit-for-bit. In that mode the default-NaN input has no effect.

An invalid-operation flag marks any signalling NaN operand. The comparison itself is combinational. The result, the flag and a valid strobe are registered, so the outputs appear one cycle after the input is presented.

Top module: `fp_pair_min`

## Requirements
- R1: The format code selects the element width and the position of the two elements in `src_i`: code 0 is 16-bit (elements at [15:0] and [31:16]), code 1 is 32-bit ([31:0] and [63:32]), and codes 2 and 3 are 64-bit ([63:0] and [127:64]). Source bits above the selected slice are ignored, and the result is zero-extended to 64 bits.
- R2: `res_valid_o` equals `in_valid_i` from the previous clock. `result_o` and `invalid_o` hold their values while `in_valid_i` is low.
- R3: Non-NaN, non-zero-pair operands are ordered by sign and magnitude. Subnormals are compared exactly, without flushing, and infinities order normally. The smaller operand is returned unchanged.
- R4: With `alt_mode_i` low, a pair of zeros of opposite sign returns negative zero, whichever element holds it.
- R5: With both modes low and a NaN operand present, the result is chosen in this order: a signalling first element, a signalling second element, a quiet first element, then the quiet second element. The chosen NaN is returned with its top fraction bit set.
- R6: With `alt_mode_i` low, `dnan_mode_i` high and a NaN operand present, the result is the default NaN of the selected format: 16'h7E00, 32'h7FC0_0000 or 64'h7FF8_0000_0000_0000.
- R7: With `alt_mode_i` high and both elements zero, of any signs, the result is the second element unchanged.
- R8: With `alt_mode_i` high and either element a NaN, the result is the second element unchanged, whatever the value of `dnan_mode_i`.
- R9: `invalid_o` is high with a result exactly when either element is a signalling NaN, in both modes. A signalling NaN has an all-ones exponent, a non-zero fraction and a clear top fraction bit. Quiet NaNs alone leave the flag low.
- R10: While `rst` is high at a clock edge, `res_valid_o`, `result_o` and `invalid_o` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Source operand presented this cycle |
| fmt_i | input | 2 | Element format code (0 half, 1 single, 2/3 double) |
| alt_mode_i | input | 1 | Alternate special-case handling |
| dnan_mode_i | input | 1 | Default-NaN mode |
| src_i | input | 128 | Packed pair of elements |
| res_valid_o | output | 1 | Result valid, one cycle after input |
| result_o | output | 64 | Minimum element, zero-extended |
| invalid_o | output | 1 | Invalid-operation flag for this result |

## Verification
The bench builds the unit with its default 64-bit maximum element width, which gives the same datapath access to all three formats, including format code 3. This setting brings the field boundaries of each format within reach: subnormal pairs, infinities, signed-zero pairs in both orders, and signalling and quiet NaNs in every combination of the two modes. A behavioural model decodes each element with integer masks and ordered keys. Its result is compared with the outputs on every clock, including idle cycles that test the hold behaviour.

// File: rtl/fpmin_pkg.sv
package fpmin_pkg;
  localparam int ELEM_MAX = 64;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_DBL_X  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic                  sign;
    logic                  zero;
    logic                  nan;
    logic                  snan;
    logic [ELEM_MAX-2:0]   mag;
    logic [ELEM_MAX-1:0]   quieted;
  } elem_cls_t;
endpackage

// File: rtl/fpmin_unpack.sv
module fpmin_unpack
  import fpmin_pkg::*;
#(
  parameter int EW = ELEM_MAX,
  localparam int SW = 2 * EW
) (
  input  logic [SW-1:0] src,
  input  logic [1:0]    fmt,
  output logic [EW-1:0] first,
  output logic [EW-1:0] second
);
  always_comb begin
    first  = '0;
    second = '0;
    case (fmt)
      FMT_HALF: begin
        first[15:0]  = src[15:0];
        second[15:0] = src[31:16];
      end
      FMT_SINGLE: begin
        first[31:0]  = src[31:0];
        second[31:0] = src[63:32];
      end
      default: begin
        first  = src[EW-1:0];
        second = src[SW-1:EW];
      end
    endcase
  end
endmodule

// File: rtl/fpmin_classify.sv
module fpmin_classify
  import fpmin_pkg::*;
#(
  parameter int EW = ELEM_MAX
) (
  input  logic [EW-1:0] elem,
  input  logic [1:0]    fmt,
  output elem_cls_t     cls
);
  logic exp_ones, frac_nz, top_frac;

  always_comb begin
    cls = '0;
    case (fmt)
      FMT_HALF: begin
        exp_ones    = &elem[14:10];
        frac_nz     = |elem[9:0];
        top_frac    = elem[9];
        cls.sign    = elem[15];
        cls.mag     = {{(EW-16){1'b0}}, elem[14:0]};
        cls.quieted = elem | (EW'(1) << 9);
      end
      FMT_SINGLE: begin
        exp_ones    = &elem[30:23];
        frac_nz     = |elem[22:0];
        top_frac    = elem[22];
        cls.sign    = elem[31];
        cls.mag     = {{(EW-32){1'b0}}, elem[30:0]};
        cls.quieted = elem | (EW'(1) << 22);
      end
      default: begin
        exp_ones    = &elem[62:52];
        frac_nz     = |elem[51:0];
        top_frac    = elem[51];
        cls.sign    = elem[63];
        cls.mag     = elem[62:0];
        cls.quieted = elem | (EW'(1) << 51);
      end
    endcase
    cls.zero = (cls.mag == '0);
    cls.nan  = exp_ones & frac_nz;
    cls.snan = exp_ones & frac_nz & ~top_frac;
  end
endmodule

// File: rtl/fpmin_pick.sv
module fpmin_pick
  import fpmin_pkg::*;
#(
  parameter int EW = ELEM_MAX
) (
  input  elem_cls_t     ca,
  input  elem_cls_t     cb,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic [1:0]    fmt,
  input  logic          alt,
  input  logic          dnan,
  output logic [EW-1:0] res,
  output logic          inv
);
  logic          a_less;
  logic          any_nan;
  logic [EW-1:0] ordered;
  logic [EW-1:0] dflt;
  logic [EW-1:0] prop;

  always_comb begin
    if (ca.sign != cb.sign) a_less = ca.sign;
    else if (ca.sign)       a_less = (ca.mag > cb.mag);
    else                    a_less = (ca.mag < cb.mag);
    ordered = a_less ? a : b;
  end

  always_comb begin
    case (fmt)
      FMT_HALF:   dflt = EW'(16'h7E00);
      FMT_SINGLE: dflt = EW'(32'h7FC0_0000);
      default:    dflt = EW'(64'h7FF8_0000_0000_0000);
    endcase
  end

  always_comb begin
    if (ca.snan)      prop = ca.quieted;
    else if (cb.snan) prop = cb.quieted;
    else if (ca.nan)  prop = a;
    else              prop = b;
  end

  assign any_nan = ca.nan | cb.nan;
  assign inv     = ca.snan | cb.snan;

  always_comb begin
    if (alt) begin
      res = (any_nan || (ca.zero && cb.zero)) ? b : ordered;
    end else if (any_nan) begin
      res = dnan ? dflt : prop;
    end else begin
      res = ordered;
    end
  end
endmodule

// File: rtl/fp_pair_min.sv
module fp_pair_min
  import fpmin_pkg::*;
#(
  parameter int EW = ELEM_MAX,
  localparam int SW = 2 * EW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid_i,
  input  logic [1:0]    fmt_i,
  input  logic          alt_mode_i,
  input  logic          dnan_mode_i,
  input  logic [SW-1:0] src_i,
  output logic          res_valid_o,
  output logic [EW-1:0] result_o,
  output logic          invalid_o
);
  logic [EW-1:0] elem [2];
  elem_cls_t     cls  [2];
  logic [EW-1:0] res_c;
  logic          inv_c;

  fpmin_unpack #(.EW(EW)) u_unpack (
    .src    (src_i),
    .fmt    (fmt_i),
    .first  (elem[0]),
    .second (elem[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpmin_classify #(.EW(EW)) u_cls (
      .elem (elem[g]),
      .fmt  (fmt_i),
      .cls  (cls[g])
    );
  end

  fpmin_pick #(.EW(EW)) u_pick (
    .ca   (cls[0]),
    .cb   (cls[1]),
    .a    (elem[0]),
    .b    (elem[1]),
    .fmt  (fmt_i),
    .alt  (alt_mode_i),
    .dnan (dnan_mode_i),
    .res  (res_c),
    .inv  (inv_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      result_o    <= '0;
      invalid_o   <= 1'b0;
    end else begin
      res_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o  <= res_c;
        invalid_o <= inv_c;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> res_valid_o);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> (!res_valid_o && $stable(result_o) && $stable(invalid_o)));

  assert_half_zero_ext_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && fmt_i == FMT_HALF) |=> (result_o[EW-1:16] == '0));

  assert_alt_nan_second_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && alt_mode_i && (cls[0].nan || cls[1].nan))
      |=> (result_o == $past(elem[1])));

  assert_default_nan_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && !alt_mode_i && dnan_mode_i && (cls[0].nan || cls[1].nan))
      |=> (result_o == (($past(fmt_i) == 2'd0) ? EW'(16'h7E00) :
                        ($past(fmt_i) == 2'd1) ? EW'(32'h7FC0_0000) :
                                                 EW'(64'h7FF8_0000_0000_0000))));

  assert_snan_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && (cls[0].snan || cls[1].snan)) |=> invalid_o);
endmodule

// File: tb/fp_pair_min_bench.sv
module fp_pair_min_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid_i = 1'b0;
  logic [1:0]   fmt_i = '0;
  logic         alt_mode_i = 1'b0;
  logic         dnan_mode_i = 1'b0;
  logic [127:0] src_i = '0;
  logic         res_valid_o;
  logic [63:0]  result_o;
  logic         invalid_o;

  int checks = 0;
  int errors = 0;

  bit          pend_v = 1'b0;
  logic [63:0] pend_res = '0;
  bit          pend_inv = 1'b0;
  string       pend_tag = "R2";

  always #4 clk = ~clk;

  fp_pair_min u_fp_pair_min (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (in_valid_i),
    .fmt_i       (fmt_i),
    .alt_mode_i  (alt_mode_i),
    .dnan_mode_i (dnan_mode_i),
    .src_i       (src_i),
    .res_valid_o (res_valid_o),
    .result_o    (result_o),
    .invalid_o   (invalid_o)
  );

  function automatic logic [64:0] ref_min(int f, bit ah, bit dn,
                                          longint unsigned a, longint unsigned b);
    int ew, fw;
    longint unsigned fm, em, qb, ea, eb, fa, fb, ma, mb, dflt, r;
    longint signed ka, kb;
    bit sa, sb, na, nb, sna, snb, za, zb;
    ew = (f == 0) ? 16 : (f == 1) ? 32 : 64;
    fw = (f == 0) ? 10 : (f == 1) ? 23 : 52;
    fm = (64'd1 << fw) - 1;
    em = (64'd1 << (ew - 1 - fw)) - 1;
    qb = 64'd1 << (fw - 1);
    ea = (a >> fw) & em;  eb = (b >> fw) & em;
    fa = a & fm;          fb = b & fm;
    sa = bit'((a >> (ew - 1)) & 1);
    sb = bit'((b >> (ew - 1)) & 1);
    ma = a & ((64'd1 << (ew - 1)) - 1);
    mb = b & ((64'd1 << (ew - 1)) - 1);
    na = (ea == em) && (fa != 0);
    nb = (eb == em) && (fb != 0);
    sna = na && ((fa & qb) == 0);
    snb = nb && ((fb & qb) == 0);
    za = (ma == 0); zb = (mb == 0);
    ka = sa ? -$signed(ma) : $signed(ma);
    kb = sb ? -$signed(mb) : $signed(mb);
    dflt = (em << fw) | qb;
    if (ah && (na || nb || (za && zb))) r = b;
    else if (na || nb) begin
      if (dn)       r = dflt;
      else if (sna) r = a | qb;
      else if (snb) r = b | qb;
      else if (na)  r = a;
      else          r = b;
    end else if (za && zb) r = sa ? a : b;
    else r = (ka <= kb) ? a : b;
    return {sna | snb, r};
  endfunction

  task automatic check_out();
    checks++;
    if (res_valid_o !== pend_v) begin
      errors++;
      $display("FAIL R2 valid actual=%0b expected=%0b", res_valid_o, pend_v);
    end
    if (pend_v) begin
      checks++;
      if (result_o !== pend_res) begin
        errors++;
        $display("FAIL %s result actual=%h expected=%h", pend_tag, result_o, pend_res);
      end
      checks++;
      if (invalid_o !== pend_inv) begin
        errors++;
        $display("FAIL %s R9 invalid actual=%0b expected=%0b", pend_tag, invalid_o, pend_inv);
      end
    end
  endtask

  task automatic apply(int f, bit ah, bit dn, longint unsigned a,
                       longint unsigned b, string tag, bit junk = 1'b0);
    logic [64:0] e;
    @(negedge clk);
    check_out();
    in_valid_i  = 1'b1;
    fmt_i       = 2'(f);
    alt_mode_i  = ah;
    dnan_mode_i = dn;
    src_i       = junk ? {4{32'hDEAD_BEEF}} : '0;
    case (f)
      0:       begin src_i[15:0] = a[15:0]; src_i[31:16] = b[15:0]; end
      1:       begin src_i[31:0] = a[31:0]; src_i[63:32] = b[31:0]; end
      default: src_i = {b, a};
    endcase
    e        = ref_min(f, ah, dn, a & mask(f), b & mask(f));
    pend_v   = 1'b1;
    pend_res = e[63:0];
    pend_inv = e[64];
    pend_tag = tag;
  endtask

  function automatic longint unsigned mask(int f);
    return (f == 0) ? 64'hFFFF : (f == 1) ? 64'hFFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  task automatic idle(string tag);
    @(negedge clk);
    check_out();
    in_valid_i = 1'b0;
    src_i      = {4{32'h0BAD_F00D}};
    pend_v     = 1'b0;
    pend_tag   = tag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({res_valid_o, result_o, invalid_o} !== '0) begin
      errors++;
      $display("FAIL R10 reset actual=%0b/%h/%0b expected=0/0/0",
               res_valid_o, result_o, invalid_o);
    end
    rst = 1'b0;
    // R3 ordering
    apply(0, 0, 0, 64'h3C00, 64'hC000, "R3");
    apply(0, 0, 0, 64'h0002, 64'h0001, "R3");
    apply(0, 0, 0, 64'h8001, 64'h8002, "R3");
    apply(1, 0, 0, 64'h7F80_0000, 64'h3F80_0000, "R3");
    apply(1, 0, 0, 64'hBF80_0000, 64'hFF80_0000, "R3");
    apply(2, 0, 0, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R3");
    apply(2, 1, 0, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, "R3");
    // R1 formats and ignored bits
    apply(0, 0, 0, 64'h4400, 64'h4200, "R1", 1'b1);
    apply(1, 0, 0, 64'h4000_0000, 64'hC000_0000, "R1", 1'b1);
    apply(3, 0, 0, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001, "R1");
    // R2 idle hold
    idle("R2");
    idle("R2");
    // R4 signed zeros
    apply(0, 0, 0, 64'h8000, 64'h0000, "R4");
    apply(0, 0, 0, 64'h0000, 64'h8000, "R4");
    apply(1, 0, 1, 64'h0000_0000, 64'h8000_0000, "R4");
    apply(2, 0, 0, 64'h8000_0000_0000_0000, 64'h0, "R4");
    // R5 NaN propagation
    apply(0, 0, 0, 64'h7E01, 64'h3C00, "R5");
    apply(0, 0, 0, 64'h7E02, 64'h7C01, "R5");
    apply(0, 0, 0, 64'h7C02, 64'h7C03, "R5");
    apply(0, 0, 0, 64'h3C00, 64'hFE05, "R5");
    apply(1, 0, 0, 64'h7F80_0001, 64'h0, "R5");
    apply(2, 0, 0, 64'h7FF8_0000_0000_0003, 64'h7FF0_0000_0000_0004, "R5");
    // R6 default NaN
    apply(0, 0, 1, 64'h7C01, 64'h1234, "R6");
    apply(1, 0, 1, 64'h3F80_0000, 64'hFFC0_0001, "R6");
    apply(2, 0, 1, 64'h7FF8_0000_0000_0009, 64'h0, "R6");
    // R7 alternate zeros
    apply(0, 1, 0, 64'h8000, 64'h0000, "R7");
    apply(1, 1, 0, 64'h0000_0000, 64'h8000_0000, "R7");
    apply(2, 1, 1, 64'h0, 64'h0, "R7");
    // R8 alternate NaN
    apply(0, 1, 1, 64'h7E00, 64'h3C00, "R8");
    apply(1, 1, 0, 64'h3F80_0000, 64'h7F80_0001, "R8");
    apply(2, 1, 1, 64'h7FF0_0000_0000_0001, 64'hFFF8_0000_0000_0002, "R8");
    // R9 flag corners
    apply(0, 0, 0, 64'h7E00, 64'h7E00, "R9");
    apply(1, 1, 0, 64'h7F80_0002, 64'h4000_0000, "R9");
    idle("R2");
    @(negedge clk);
    check_out();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule